// File: doc/BRIEF.md
# Pixel Readout Serial Transmitter

This block sends a line of sampled pixel values out of an image sensor over one serial wire. The line uses asynchronous character framing but runs on the shared serial clock. After a read request it waits a fixed number of clocks, which covers the conversion pipeline. It then sends every pixel in turn as a ten-bit frame: a zero start bit, eight data bits least significant first, and a one stop bit. The next frame starts directly after each stop bit.

While the stream runs, the block drives the index of the pixel being sent. It reads that pixel's value back from the fetch port. It also reports which of three equal zones the pixel belongs to. From that zone code it selects the matching gain and offset fields out of the per-zone register inputs, so that downstream analog logic applies the correct correction. An abort strobe or a reset-command strobe ends the stream at once, even in the middle of a frame. The serial line changes only on falling clock edges, so a receiver can sample it on rising edges.

Top module: `pixel_serial_tx`

## Requirements
- R1: The start bit of pixel 0 appears at the falling edge that follows the 44th rising edge after the rising edge that samples the read request. The line stays high until then, and busy is high from the edge after that request.
- R2: Each frame holds ten bit times: a start bit of 0, then the pixel value least significant bit first, then a stop bit of 1.
- R3: During a readout, the start bit of each pixel after the first follows the previous pixel's stop bit directly, with exactly one stop bit between words.
- R4: Pixels go out in index order 0 to 101, and the pixel index output names the pixel being sent. Readout ends after the stop bit of pixel 101: busy falls and the index returns to 0.
- R5: The zone output is 0 for pixels 0 to 33, 1 for 34 to 67 and 2 for 68 to 101. The gain and offset outputs carry the fields of that zone, where zone z occupies bits [5z+4:5z] of the gain input and [8z+7:8z] of the offset input.
- R6: The serial line is high whenever no frame bit is being sent: after reset, while idle, and during the latency wait.
- R7: An abort strobe ends a readout at any point, including mid-frame and during the latency wait. Busy falls on the next edge and the line is high from the next falling edge.
- R8: A reset-command strobe has the same stopping effect as an abort.
- R9: A read request while busy has no effect: the stream carries on unchanged.
- R10: The serial line changes only on falling clock edges.
- R11: The busy output is high exactly from the edge that accepts a request until readout ends or is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_i | input | 1 | Start-readout strobe |
| abort_i | input | 1 | Abort strobe |
| cmd_rst_i | input | 1 | Reset-command strobe |
| pix_idx_o | output | 7 | Index of the pixel being fetched |
| pix_val_i | input | 8 | Value of the fetched pixel |
| zone_gain_i | input | 15 | Gain fields of the three zones |
| zone_offs_i | input | 24 | Offset fields of the three zones |
| zone_o | output | 2 | Zone of the current pixel |
| gain_sel_o | output | 5 | Gain field of the current zone |
| offs_sel_o | output | 8 | Offset field of the current zone |
| busy_o | output | 1 | Readout in progress |
| sd_o | output | 1 | Serial data line |

## Verification
The bench builds the block with its default parameters: 102 pixels, 34 pixels per zone, a latency of 44 clocks and 8-bit values. With these values a full readout takes about 1,064 clocks, so several complete readouts fit in a short run. Those readouts cover both zone borders, the transition from the last pixel to idle, and every frame boundary. Stops are placed in the latency wait and in the middle of a frame. A request is also issued during an active stream, to show that a stray request has no effect.

// File: rtl/pxo_pkg.sv
package pxo_pkg;

  typedef enum logic [1:0] {
    PX_IDLE = 2'd0,
    PX_WAIT = 2'd1,
    PX_SEND = 2'd2
  } px_state_e;

  // zone of a pixel: equal-sized zones, the last one absorbs any remainder
  function automatic int unsigned zone_of(input int unsigned idx,
                                          input int unsigned zpix,
                                          input int unsigned nz);
    int unsigned q;
    q = idx / zpix;
    if (q >= nz) q = nz - 1;
    return q;
  endfunction

  // bit of a frame at a given slot: 0 start, data LSB first, then stop
  function automatic logic frame_bit(input int unsigned pos,
                                     input logic [31:0] val,
                                     input int unsigned dw);
    if (pos == 0) return 1'b0;
    if (pos > dw) return 1'b1;
    return val[pos-1];
  endfunction

endpackage

// File: rtl/pxo_seq.sv
module pxo_seq
  import pxo_pkg::*;
#(
  parameter int NUM_PIX = 102,
  parameter int LAT     = 44,
  parameter int DATA_W  = 8,
  localparam int FRAME_LEN = DATA_W + 2,
  localparam int POS_W     = $clog2(FRAME_LEN),
  localparam int IDX_W     = $clog2(NUM_PIX),
  localparam int LAT_W     = $clog2(LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             cmd_rst_i,
  output px_state_e        state_o,
  output logic [POS_W-1:0] pos_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             lat_done_o,
  output logic             frame_done_o,
  output logic             last_pix_o
);

  px_state_e        state_q;
  logic [LAT_W-1:0] wait_q;
  logic [POS_W-1:0] pos_q;
  logic [IDX_W-1:0] idx_q;
  logic             stop_now;

  assign stop_now     = abort_i | cmd_rst_i;
  assign lat_done_o   = (state_q == PX_WAIT) && (wait_q == LAT_W'(LAT - 1));
  assign frame_done_o = (state_q == PX_SEND) && (pos_q == POS_W'(FRAME_LEN - 1));
  assign last_pix_o   = (idx_q == IDX_W'(NUM_PIX - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PX_IDLE;
      wait_q  <= '0;
      pos_q   <= '0;
      idx_q   <= '0;
    end else if (stop_now) begin
      state_q <= PX_IDLE;
      wait_q  <= '0;
      pos_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        PX_IDLE: if (start_i) begin
          state_q <= PX_WAIT;
          wait_q  <= '0;
        end
        PX_WAIT: begin
          if (lat_done_o) begin
            state_q <= PX_SEND;
            pos_q   <= '0;
            idx_q   <= '0;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        PX_SEND: begin
          if (frame_done_o) begin
            pos_q <= '0;
            if (last_pix_o) begin
              state_q <= PX_IDLE;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        default: state_q <= PX_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign pos_o   = pos_q;
  assign idx_o   = idx_q;

  // R1: latency expiry leads straight into the start slot of pixel 0
  p_lat_to_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_done_o && !stop_now) |=> (state_q == PX_SEND && pos_q == '0 && idx_q == '0));

  // R4: frame completion advances to the next pixel
  p_pix_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done_o && !last_pix_o && !stop_now) |=> (idx_q == $past(idx_q) + 1'b1 && pos_q == '0));

  // R4: readout ends after the last pixel
  p_end_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done_o && last_pix_o && !stop_now) |=> (state_q == PX_IDLE));

  // R7: abort stops the stream on the next edge
  p_abort_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (state_q == PX_IDLE));

  // R8: reset command stops the stream on the next edge
  p_cmd_rst_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst_i |=> (state_q == PX_IDLE));

  // R9: a request while sending does not disturb the frame slot count
  p_req_ignored_send_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PX_SEND && !frame_done_o && start_i && !stop_now)
      |=> (state_q == PX_SEND && pos_q == $past(pos_q) + 1'b1));

  // R9: a request while waiting does not restart the latency
  p_req_ignored_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PX_WAIT && !lat_done_o && start_i && !stop_now)
      |=> (state_q == PX_WAIT && wait_q == $past(wait_q) + 1'b1));

endmodule

// File: rtl/pxo_zone_sel.sv
module pxo_zone_sel
  import pxo_pkg::*;
#(
  parameter int NUM_PIX  = 102,
  parameter int ZONE_PIX = 34,
  parameter int NZONES   = 3,
  parameter int GAIN_W   = 5,
  parameter int OFFS_W   = 8,
  localparam int IDX_W   = $clog2(NUM_PIX),
  localparam int ZSEL_W  = $clog2(NZONES)
) (
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [NZONES*GAIN_W-1:0] gain_regs_i,
  input  logic [NZONES*OFFS_W-1:0] offs_regs_i,
  output logic [ZSEL_W-1:0]        zone_o,
  output logic [GAIN_W-1:0]        gain_o,
  output logic [OFFS_W-1:0]        offs_o
);

  logic [GAIN_W-1:0] gain_arr [NZONES];
  logic [OFFS_W-1:0] offs_arr [NZONES];

  for (genvar z = 0; z < NZONES; z++) begin : g_zone
    assign gain_arr[z] = gain_regs_i[z*GAIN_W +: GAIN_W];
    assign offs_arr[z] = offs_regs_i[z*OFFS_W +: OFFS_W];
  end

  assign zone_o = ZSEL_W'(zone_of(32'(idx_i), ZONE_PIX, NZONES));
  assign gain_o = gain_arr[zone_o];
  assign offs_o = offs_arr[zone_o];

endmodule

// File: rtl/pxo_line_drv.sv
module pxo_line_drv
  import pxo_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int POS_W = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sending_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [DATA_W-1:0] val_i,
  output logic              sd_o
);

  logic line_nxt;

  assign line_nxt = sending_i ? frame_bit(32'(pos_i), 32'(val_i), DATA_W) : 1'b1;

  // launch on the falling edge so the line is settled at the rising edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sd_o <= 1'b1;
    else        sd_o <= line_nxt;
  end

endmodule

// File: rtl/pixel_serial_tx.sv
module pixel_serial_tx
  import pxo_pkg::*;
#(
  parameter int NUM_PIX  = 102,
  parameter int ZONE_PIX = 34,
  parameter int NZONES   = 3,
  parameter int LAT      = 44,
  parameter int DATA_W   = 8,
  parameter int GAIN_W   = 5,
  parameter int OFFS_W   = 8,
  localparam int IDX_W     = $clog2(NUM_PIX),
  localparam int ZSEL_W    = $clog2(NZONES),
  localparam int FRAME_LEN = DATA_W + 2,
  localparam int POS_W     = $clog2(FRAME_LEN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_req_i,
  input  logic                     abort_i,
  input  logic                     cmd_rst_i,
  output logic [IDX_W-1:0]         pix_idx_o,
  input  logic [DATA_W-1:0]        pix_val_i,
  input  logic [NZONES*GAIN_W-1:0] zone_gain_i,
  input  logic [NZONES*OFFS_W-1:0] zone_offs_i,
  output logic [ZSEL_W-1:0]        zone_o,
  output logic [GAIN_W-1:0]        gain_sel_o,
  output logic [OFFS_W-1:0]        offs_sel_o,
  output logic                     busy_o,
  output logic                     sd_o
);

  px_state_e        seq_state;
  logic [POS_W-1:0] seq_pos;
  logic             lat_done;
  logic             frame_done;
  logic             last_pix;
  logic             sending;

  pxo_seq #(.NUM_PIX(NUM_PIX), .LAT(LAT), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (rd_req_i),
    .abort_i     (abort_i),
    .cmd_rst_i   (cmd_rst_i),
    .state_o     (seq_state),
    .pos_o       (seq_pos),
    .idx_o       (pix_idx_o),
    .lat_done_o  (lat_done),
    .frame_done_o(frame_done),
    .last_pix_o  (last_pix)
  );

  pxo_zone_sel #(.NUM_PIX(NUM_PIX), .ZONE_PIX(ZONE_PIX), .NZONES(NZONES),
                 .GAIN_W(GAIN_W), .OFFS_W(OFFS_W)) u_zone (
    .idx_i      (pix_idx_o),
    .gain_regs_i(zone_gain_i),
    .offs_regs_i(zone_offs_i),
    .zone_o     (zone_o),
    .gain_o     (gain_sel_o),
    .offs_o     (offs_sel_o)
  );

  assign sending = (seq_state == PX_SEND);
  assign busy_o  = (seq_state != PX_IDLE);

  pxo_line_drv #(.DATA_W(DATA_W)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .sending_i(sending),
    .pos_i    (seq_pos),
    .val_i    (pix_val_i),
    .sd_o     (sd_o)
  );

  // R6: the line launched for an idle state is high
  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sd_o);

  // R2: start slot carries a low bit
  p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && seq_pos == '0) |-> !sd_o);

  // R2: stop slot carries a high bit
  p_stop_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && seq_pos == POS_W'(FRAME_LEN - 1)) |-> sd_o);

  // R5: crossing the first zone border selects the second zone
  p_zone_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_idx_o == IDX_W'(ZONE_PIX) && $past(pix_idx_o) == IDX_W'(ZONE_PIX - 1))
      |-> (zone_o == ZSEL_W'(1)));

  // R11: busy rises only after a request
  p_busy_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(rd_req_i));

endmodule

// File: tb/pixel_serial_tx_tb_top.sv
`timescale 1ns/100ps
module pixel_serial_tx_tb_top;

  localparam int NUM_PIX = 102;
  localparam int ZPIX    = 34;
  localparam int LAT     = 44;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic        abort = 1'b0;
  logic        cmd_rst = 1'b0;
  logic [6:0]  pix_idx;
  logic [7:0]  pix_val;
  logic [14:0] gain_regs;
  logic [23:0] offs_regs;
  logic [1:0]  zone;
  logic [4:0]  gain_sel;
  logic [7:0]  offs_sel;
  logic        busy;
  logic        sd;

  logic [7:0] pix_mem [NUM_PIX];
  logic [4:0] g_tab [3];
  logic [7:0] o_tab [3];

  always #2 clk = ~clk;

  assign pix_val   = pix_mem[pix_idx];
  assign gain_regs = {g_tab[2], g_tab[1], g_tab[0]};
  assign offs_regs = {o_tab[2], o_tab[1], o_tab[0]};

  pixel_serial_tx dut_i (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req), .abort_i(abort),
    .cmd_rst_i(cmd_rst), .pix_idx_o(pix_idx), .pix_val_i(pix_val),
    .zone_gain_i(gain_regs), .zone_offs_i(offs_regs), .zone_o(zone),
    .gain_sel_o(gain_sel), .offs_sel_o(offs_sel), .busy_o(busy), .sd_o(sd)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit run_model = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, exp);
    end
  endtask

  // expected stream, one entry per falling edge
  bit    q_bit [$];
  int    q_idx [$];
  string q_tag [$];

  logic  exp_sd = 1'b1;
  logic  exp_busy = 1'b0;
  int    exp_idx = 0;
  string exp_tag = "R6";

  task automatic push(input bit b, input int i, input string t);
    q_bit.push_back(b); q_idx.push_back(i); q_tag.push_back(t);
  endtask

  task automatic load_readout();
    for (int k = 0; k < LAT; k++) push(1'b1, 0, "R1");
    for (int p = 0; p < NUM_PIX; p++) begin
      push(1'b0, p, (p == 0) ? "R1" : "R3");
      for (int b = 0; b < 8; b++) push(pix_mem[p][b], p, "R2");
      push(1'b1, p, (p == NUM_PIX - 1) ? "R4" : "R2");
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (run_model) begin
      logic seen;
      seen = sd;
      chk(sd === exp_sd, exp_tag, "serial line", int'(sd), int'(exp_sd));
      if (abort || cmd_rst) begin
        q_bit.delete(); q_idx.delete(); q_tag.delete();
      end else if (rd_req && q_bit.size() == 0) begin
        load_readout();
      end
      if (q_bit.size() != 0) begin
        exp_sd = q_bit.pop_front();
        exp_idx = q_idx.pop_front();
        exp_tag = q_tag.pop_front();
        exp_busy = 1'b1;
      end else begin
        exp_sd = 1'b1; exp_idx = 0; exp_busy = 1'b0;
        exp_tag = abort ? "R7" : (cmd_rst ? "R8" : "R6");
      end
      #1;
      chk(sd === seen, "R10", "line moved near rising edge", int'(sd), int'(seen));
    end
  end

  always @(negedge clk) begin
    if (run_model) begin
      #1;
      chk(busy === exp_busy, "R11", "busy", int'(busy), int'(exp_busy));
      chk(int'(pix_idx) == exp_idx, "R4", "pixel index", int'(pix_idx), exp_idx);
      chk(int'(zone) == exp_idx / ZPIX, "R5", "zone", int'(zone), exp_idx / ZPIX);
      chk(gain_sel === g_tab[exp_idx / ZPIX], "R5", "gain select",
          int'(gain_sel), int'(g_tab[exp_idx / ZPIX]));
      chk(offs_sel === o_tab[exp_idx / ZPIX], "R5", "offset select",
          int'(offs_sel), int'(o_tab[exp_idx / ZPIX]));
    end
  end

  task automatic pulse(input int which);
    @(posedge clk); #0.5;
    if (which == 0) rd_req = 1'b1;
    else if (which == 1) abort = 1'b1;
    else cmd_rst = 1'b1;
    @(posedge clk); #0.5;
    rd_req = 1'b0; abort = 1'b0; cmd_rst = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int old_idx;
    g_tab[0] = 5'd3;  g_tab[1] = 5'd17; g_tab[2] = 5'd30;
    o_tab[0] = 8'h05; o_tab[1] = 8'h83; o_tab[2] = 8'h7e;
    for (int p = 0; p < NUM_PIX; p++) pix_mem[p] = 8'((p * 37 + 5) & 255);
    repeat (3) @(posedge clk);
    #1;
    // reset state
    chk(sd === 1'b1, "R6", "line in reset", int'(sd), 1);
    chk(busy === 1'b0, "R11", "busy in reset", int'(busy), 0);
    chk(pix_idx == 7'd0, "R4", "index in reset", int'(pix_idx), 0);
    @(posedge clk); #0.5;
    rst_n = 1'b1;
    @(posedge clk); #0.5;
    run_model = 1;

    // full readout, ramp-like values
    pulse(0);
    idle(1100);

    // extreme and alternating values, stray request mid-stream
    for (int p = 0; p < NUM_PIX; p++)
      pix_mem[p] = (p % 4 == 0) ? 8'h00 : (p % 4 == 1) ? 8'hff : (p % 4 == 2) ? 8'h55 : 8'haa;
    pulse(0);
    idle(300);
    #1.5;
    old_idx = int'(pix_idx);
    pulse(0);
    idle(20);
    #1.5;
    chk(busy === 1'b1 && int'(pix_idx) >= old_idx, "R9", "stream kept after stray request",
        int'(pix_idx), old_idx);
    idle(800);

    // abort in the middle of a frame
    pulse(0);
    idle(LAT + 503);
    pulse(1);
    #1;
    chk(busy === 1'b0, "R7", "busy after abort", int'(busy), 0);
    idle(2);
    #1;
    chk(sd === 1'b1, "R7", "line after abort", int'(sd), 1);
    idle(30);

    // abort during the latency wait
    pulse(0);
    idle(20);
    pulse(1);
    idle(80);
    #1;
    chk(sd === 1'b1 && busy === 1'b0, "R7", "idle after early abort", int'(busy), 0);

    // reset command mid-frame
    for (int p = 0; p < NUM_PIX; p++) pix_mem[p] = 8'((p * 91 + 200) & 255);
    pulse(0);
    idle(800);
    pulse(2);
    #1;
    chk(busy === 1'b0, "R8", "busy after reset command", int'(busy), 0);
    idle(10);

    // fresh readout after the reset command
    pulse(0);
    idle(1100);
    #1;
    chk(busy === 1'b0 && pix_idx == 7'd0, "R4", "end of readout", int'(busy), 0);

    run_model = 0;
    idle(2);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule